// File: doc/BRIEF.md
# Rate-1/3 Parallel Concatenated Convolutional Encoder

This block turns a 40-bit information frame into a rate-1/3 coded stream. A start pulse opens a loading phase in which the frame bits are accepted one per handshake and stored in an internal buffer. Once the last bit is stored, two identical recursive systematic convolutional encoders step together, one beat per accepted output. The first encoder reads the buffer in natural order. The second reads it through a permutation address generator. Each beat carries one systematic bit and one parity bit from each encoder.

Only the first encoder's systematic bit is sent during data beats, because the second encoder's input is a reordering of the same bits. For monitoring, the second encoder's input bit is still shown on a separate output. After the 40 data beats, three tail beats drive both encoders back to the all-zero state. During these beats each encoder's own termination input appears on its systematic output. The output side uses a valid/ready handshake. A downstream stall freezes the current beat.

Top module: `pccc_encoder`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `in_ready` and `out_valid` are both 0.
- R2: A `start` pulse while idle raises `in_ready` in the next cycle. Frame bit k (k = 0..39) is the k-th bit accepted with `in_valid && in_ready`. `in_ready` falls in the cycle after bit 39 is accepted.
- R3: No output beat is offered until all 40 bits are stored. `in_ready` and `out_valid` are never high in the same cycle.
- R4: Data beat i uses permuted address p(i) = (3·i + 10·i²) mod 40. This address always lies in 0..39.
- R5: Each encoder has three state bits d1, d2, d3, cleared at every frame start. For each step with input u:
  - fb = d2 ^ d3
  - a = u ^ fb
  - parity = a ^ d1 ^ d3
  - the next state is (d1, d2, d3) = (a, d1, d2)
- R6: There are exactly 40 data beats, with `out_tail` = 0. On beat i:
  - `out_sys` is frame bit i
  - `out_sys2` is frame bit p(i)
  - `out_par1` and `out_par2` are the parities of the natural-order and permuted-order encoders
- R7: Three tail beats follow, with `out_tail` = 1. On each, every encoder's input equals its own fb. `out_sys` and `out_sys2` carry those inputs, and the parities follow R5. `out_last` is 1 only on the third tail beat, and both encoder states are zero after it.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and all beat outputs hold their values. No beat is lost or repeated.
- R9: A `start` pulse outside the idle phase has no effect on the phase or on the stream.
- R10: After the last tail beat is accepted, the block is idle. It accepts a new frame, and the new frame's results do not depend on the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens frame loading when idle |
| in_valid | input | 1 | Frame bit present |
| in_bit | input | 1 | Frame bit value |
| in_ready | output | 1 | Block accepts a frame bit |
| out_valid | output | 1 | Coded beat present |
| out_ready | input | 1 | Downstream accepts the beat |
| out_sys | output | 1 | Systematic bit (natural-order encoder input) |
| out_par1 | output | 1 | Natural-order encoder parity |
| out_par2 | output | 1 | Permuted-order encoder parity |
| out_sys2 | output | 1 | Permuted-order encoder input bit |
| out_tail | output | 1 | Beat is a termination beat |
| out_last | output | 1 | Final beat of the frame |

## Verification
The assertions watch several properties on every cycle:
- the input and output phases never overlap
- a stalled beat stays frozen
- the permuted address stays in range
- `out_last` only comes with a tail beat
- both encoder states are zero right after the final beat
- stray start pulses leave the active phase alone

The bit-exact content of the stream can only be shown by the bench scenarios: the parity sequences, the permuted order and the tail values. The bench compares every beat with a reference model fed from the frame, under these conditions:
- zero frames, all-ones frames and alternating frames
- single-bit frames at both ends
- irregular input gaps and random downstream stalls

// File: rtl/pccc_pkg.sv
package pccc_pkg;

    localparam int MEM_BITS = 3;
    localparam int TAIL_BEATS = MEM_BITS;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOAD,
        PH_DATA,
        PH_TAIL
    } phase_t;

    typedef struct packed {
        logic                in_used;
        logic                parity;
        logic [MEM_BITS-1:0] nxt;
    } rsc_step_t;

    // state bit 0 = d1 (newest), bit 2 = d3 (oldest)
    function automatic rsc_step_t rsc_step(input logic [MEM_BITS-1:0] st,
                                           input logic u,
                                           input logic term);
        rsc_step_t r;
        logic fb;
        logic a;
        fb = st[1] ^ st[2];
        r.in_used = term ? fb : u;
        a = r.in_used ^ fb;
        r.parity = a ^ st[0] ^ st[2];
        r.nxt = {st[1], st[0], a};
        return r;
    endfunction

endpackage

// File: rtl/rsc_encoder.sv
module rsc_encoder
    import pccc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                adv,
    input  logic                term,
    input  logic                u,
    output logic                sys_bit,
    output logic                par_bit,
    output logic [MEM_BITS-1:0] state
);
    rsc_step_t step;

    always_comb begin
        step    = rsc_step(state, u, term);
        sys_bit = step.in_used;
        par_bit = step.parity;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state <= '0;
        end else if (adv) begin
            state <= step.nxt;
        end
    end
endmodule

// File: rtl/perm_addr_gen.sv
module perm_addr_gen #(
    parameter int LEN = 40,
    parameter int F1  = 3,
    parameter int F2  = 10,
    parameter int W   = $clog2(LEN)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         adv,
    output logic [W-1:0] addr
);
    localparam int START_STEP = (F1 + F2) % LEN;
    localparam int STEP_INC   = (2 * F2) % LEN;

    logic [W-1:0] delta;
    logic [W:0]   addr_sum;
    logic [W:0]   delta_sum;

    always_comb begin
        addr_sum  = {1'b0, addr} + {1'b0, delta};
        delta_sum = {1'b0, delta} + (W+1)'(STEP_INC);
        if (addr_sum >= (W+1)'(LEN)) addr_sum = addr_sum - (W+1)'(LEN);
        if (delta_sum >= (W+1)'(LEN)) delta_sum = delta_sum - (W+1)'(LEN);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            addr  <= '0;
            delta <= W'(START_STEP);
        end else if (adv) begin
            addr  <= addr_sum[W-1:0];
            delta <= delta_sum[W-1:0];
        end
    end
endmodule

// File: rtl/frame_store.sv
module frame_store #(
    parameter int LEN = 40,
    parameter int W   = $clog2(LEN)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] waddr,
    input  logic         wbit,
    input  logic [W-1:0] raddr_a,
    input  logic [W-1:0] raddr_b,
    output logic         rbit_a,
    output logic         rbit_b
);
    logic [LEN-1:0] bits_q;

    assign rbit_a = bits_q[raddr_a];
    assign rbit_b = bits_q[raddr_b];

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
        end else if (we) begin
            bits_q[waddr] <= wbit;
        end
    end
endmodule

// File: rtl/pccc_encoder.sv
module pccc_encoder
    import pccc_pkg::*;
#(
    parameter int FRAME_LEN = 40,
    parameter int PERM_F1   = 3,
    parameter int PERM_F2   = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic in_valid,
    input  logic in_bit,
    output logic in_ready,
    output logic out_valid,
    input  logic out_ready,
    output logic out_sys,
    output logic out_par1,
    output logic out_par2,
    output logic out_sys2,
    output logic out_tail,
    output logic out_last
);
    localparam int IDX_W  = $clog2(FRAME_LEN);
    localparam int TCNT_W = $clog2(TAIL_BEATS);

    phase_t              phase;
    logic [IDX_W-1:0]    idx;
    logic [TCNT_W-1:0]   tail_cnt;
    logic [IDX_W-1:0]    perm_addr;
    logic                nat_bit;
    logic                perm_bit;
    logic [MEM_BITS-1:0] enc1_state;
    logic [MEM_BITS-1:0] enc2_state;
    logic                fire_in;
    logic                fire_out;
    logic                frame_clr;
    logic                step_adv;
    logic                is_tail;

    assign in_ready  = (phase == PH_LOAD);
    assign out_valid = (phase == PH_DATA) || (phase == PH_TAIL);
    assign is_tail   = (phase == PH_TAIL);
    assign out_tail  = is_tail;
    assign out_last  = is_tail && (tail_cnt == TCNT_W'(TAIL_BEATS - 1));
    assign fire_in   = in_valid && in_ready;
    assign fire_out  = out_valid && out_ready;
    assign frame_clr = (phase == PH_IDLE) && start;
    assign step_adv  = fire_out;

    frame_store #(.LEN(FRAME_LEN), .W(IDX_W)) store_i (
        .clk     (clk),
        .rst     (rst),
        .we      (fire_in),
        .waddr   (idx),
        .wbit    (in_bit),
        .raddr_a (idx),
        .raddr_b (perm_addr),
        .rbit_a  (nat_bit),
        .rbit_b  (perm_bit)
    );

    perm_addr_gen #(.LEN(FRAME_LEN), .F1(PERM_F1), .F2(PERM_F2), .W(IDX_W)) addr_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (frame_clr),
        .adv  (fire_out && !is_tail),
        .addr (perm_addr)
    );

    rsc_encoder enc_nat_i (
        .clk     (clk),
        .rst     (rst),
        .clr     (frame_clr),
        .adv     (step_adv),
        .term    (is_tail),
        .u       (nat_bit),
        .sys_bit (out_sys),
        .par_bit (out_par1),
        .state   (enc1_state)
    );

    rsc_encoder enc_perm_i (
        .clk     (clk),
        .rst     (rst),
        .clr     (frame_clr),
        .adv     (step_adv),
        .term    (is_tail),
        .u       (perm_bit),
        .sys_bit (out_sys2),
        .par_bit (out_par2),
        .state   (enc2_state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            idx      <= '0;
            tail_cnt <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_LOAD;
                        idx   <= '0;
                    end
                end
                PH_LOAD: begin
                    if (fire_in) begin
                        if (idx == IDX_W'(FRAME_LEN - 1)) begin
                            phase <= PH_DATA;
                            idx   <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                PH_DATA: begin
                    if (fire_out) begin
                        if (idx == IDX_W'(FRAME_LEN - 1)) begin
                            phase    <= PH_TAIL;
                            tail_cnt <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                PH_TAIL: begin
                    if (fire_out) begin
                        if (out_last) begin
                            phase <= PH_IDLE;
                        end else begin
                            tail_cnt <= tail_cnt + 1'b1;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pccc_encoder_chk.sv
module pccc_encoder_chk #(
    parameter int FRAME_LEN = 40,
    parameter int IDX_W     = 6,
    parameter int ST_W      = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_sys,
    input logic             out_par1,
    input logic             out_par2,
    input logic             out_sys2,
    input logic             out_tail,
    input logic             out_last,
    input logic [ST_W-1:0]  st1,
    input logic [ST_W-1:0]  st2,
    input logic [IDX_W-1:0] addr
);
    a_r3_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid &&
            $stable({out_sys, out_par1, out_par2, out_sys2, out_tail, out_last})));

    a_r7_end_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> (st1 == '0 && st2 == '0 && !out_valid));

    a_r7_last_in_tail: assert property (@(posedge clk) disable iff (rst)
        out_last |-> (out_tail && out_valid));

    a_r4_addr_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (addr < IDX_W'(FRAME_LEN)));

    a_r9_start_in_output: assert property (@(posedge clk) disable iff (rst)
        (start && out_valid && !out_ready) |=> out_valid);

    a_r9_start_in_load: assert property (@(posedge clk) disable iff (rst)
        (start && in_ready && !in_valid) |=> in_ready);

    a_r2_load_entry: assert property (@(posedge clk) disable iff (rst)
        (start && !in_ready && !out_valid) |=> in_ready);
endmodule

bind pccc_encoder pccc_encoder_chk #(
    .FRAME_LEN (FRAME_LEN),
    .IDX_W     (IDX_W),
    .ST_W      (pccc_pkg::MEM_BITS)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sys   (out_sys),
    .out_par1  (out_par1),
    .out_par2  (out_par2),
    .out_sys2  (out_sys2),
    .out_tail  (out_tail),
    .out_last  (out_last),
    .st1       (enc1_state),
    .st2       (enc2_state),
    .addr      (perm_addr)
);

// File: tb/pccc_encoder_tb_top.sv
module pccc_encoder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LEN = 40;
    localparam int WATCHDOG_CYCLES = 150000;

    typedef struct packed {
        logic sys;
        logic p1;
        logic p2;
        logic sys2;
        logic tail;
        logic last;
    } beat_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic in_ready;
    logic out_valid;
    logic out_ready;
    logic out_sys, out_par1, out_par2, out_sys2, out_tail, out_last;

    int checks = 0;
    int fails = 0;
    bit bp_on = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    beat_t exp_q[$];
    bit held = 1'b0;
    beat_t held_v;

    always #(CLK_PERIOD/2) clk = ~clk;

    pccc_encoder dut_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .in_valid  (in_valid),
        .in_bit    (in_bit),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_sys   (out_sys),
        .out_par1  (out_par1),
        .out_par2  (out_par2),
        .out_sys2  (out_sys2),
        .out_tail  (out_tail),
        .out_last  (out_last)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int perm(input int i);
        return (3 * i + 10 * i * i) % LEN;
    endfunction

    // Reference encoder step from R5: d[0]=d1, d[1]=d2, d[2]=d3
    task automatic ref_step(inout logic [2:0] d, input logic u, input bit term,
                            output logic used, output logic par);
        logic fb, a;
        fb = d[1] ^ d[2];
        used = term ? fb : u;
        a = used ^ fb;
        par = a ^ d[0] ^ d[2];
        d = {d[1], d[0], a};
    endtask

    task automatic push_expected(input logic [LEN-1:0] f);
        logic [2:0] d1 = 3'b000;
        logic [2:0] d2 = 3'b000;
        beat_t b;
        logic s1, s2, q1, q2;
        for (int i = 0; i < LEN; i++) begin
            ref_step(d1, f[i], 1'b0, s1, q1);
            ref_step(d2, f[perm(i)], 1'b0, s2, q2);
            b = '{sys: s1, p1: q1, p2: q2, sys2: s2, tail: 1'b0, last: 1'b0};
            exp_q.push_back(b);
        end
        for (int t = 0; t < 3; t++) begin
            ref_step(d1, 1'b0, 1'b1, s1, q1);
            ref_step(d2, 1'b0, 1'b1, s2, q2);
            b = '{sys: s1, p1: q1, p2: q2, sys2: s2, tail: 1'b1, last: (t == 2)};
            exp_q.push_back(b);
        end
    endtask

    // Monitor: sets out_ready for the coming edge, then scores the beat
    always @(negedge clk) begin
        beat_t cur, e;
        if (rst) begin
            out_ready = 1'b0;
            held = 1'b0;
        end else begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = bp_on ? (lfsr[0] | lfsr[5]) : 1'b1;
            cur = '{sys: out_sys, p1: out_par1, p2: out_par2, sys2: out_sys2,
                    tail: out_tail, last: out_last};
            if (held) begin
                check(out_valid && cur == held_v, "R8", "stalled beat changed",
                      {25'd0, out_valid, cur}, {26'd0, held_v});
            end
            if (out_valid) begin
                if (out_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R3", "unexpected beat", {26'd0, cur}, 32'd0);
                    end else begin
                        e = exp_q.pop_front();
                        check(cur == e, e.tail ? "R7" : "R6", "beat mismatch",
                              {26'd0, cur}, {26'd0, e});
                    end
                    held = 1'b0;
                end else begin
                    held = 1'b1;
                    held_v = cur;
                end
            end else begin
                held = 1'b0;
            end
        end
    end

    task automatic run_frame(input logic [LEN-1:0] f, input bit gaps, input bit noise);
        push_expected(f);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(in_ready === 1'b1, "R2", "in_ready after start", {31'd0, in_ready}, 1);
        for (int i = 0; i < LEN; i++) begin
            if (gaps && (i % 7 == 3)) begin
                in_valid = 1'b0;
                if (i == 10) start = 1'b1; // R9: stray start while loading
                @(negedge clk);
                start = 1'b0;
            end
            check(out_valid === 1'b0, "R3", "output during load", {31'd0, out_valid}, 0);
            in_valid = 1'b1;
            in_bit = f[i];
            @(negedge clk);
        end
        in_valid = 1'b0;
        check(in_ready === 1'b0, "R2", "in_ready after bit 39", {31'd0, in_ready}, 0);
        if (noise) begin
            repeat (5) @(negedge clk);
            start = 1'b1; // R9: stray start during output phase
            @(negedge clk);
            start = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        check(out_valid === 1'b0 && in_ready === 1'b0, "R10", "idle after frame",
              {30'd0, out_valid, in_ready}, 0);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(in_ready === 1'b0 && out_valid === 1'b0, "R1", "outputs in reset",
              {30'd0, in_ready, out_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready === 1'b0 && out_valid === 1'b0, "R1", "outputs after reset",
              {30'd0, in_ready, out_valid}, 0);
        // R5 R6 R7: varied frames
        run_frame(40'h00_0000_0000, 1'b0, 1'b0);
        run_frame(40'hFF_FFFF_FFFF, 1'b0, 1'b0);
        run_frame(40'hAA_AAAA_AAAA, 1'b0, 1'b0);
        run_frame(40'h00_0000_0001, 1'b0, 1'b0);   // R4: single bit at index 0
        run_frame(40'h80_0000_0000, 1'b0, 1'b0);   // R4: single bit at index 39
        // R8 with stalls, R9 with stray starts, R10 back-to-back
        bp_on = 1'b1;
        run_frame(40'h9C_3A5E_71D2, 1'b1, 1'b1);
        run_frame(40'h12_3456_789A, 1'b0, 1'b1);
        run_frame(40'h00_0000_0000, 1'b1, 1'b0);   // R10: no residue from previous frame
        bp_on = 1'b0;
        run_frame(40'h5A_F00F_C3A5, 1'b1, 1'b0);
        check(exp_q.size() == 0, "R8", "beats left unsent", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule